// File: doc/BRIEF.md
# Egress Queue Arbiter with Assignable Credit Shapers

This block decides, for one egress port, which of eight priority queues sends the next frame. Each queue reports whether it holds a frame and the length of the frame at its head. The arbiter grants the highest-priority queue that is allowed to send. It then waits until the transmit MAC reports that the frame is finished, and only then picks again. A frame in flight is never interrupted.

A pool of credit-based shapers sits beside the arbiter. Any shaper can be enabled and pointed at any queue. While a shaped queue waits, its credit climbs at a configured idle rate. When one of its frames finishes, the credit drops by a configured send rate times the byte count. A shaped queue may only be granted while its credit is zero or above. This lets audio and video stream classes be rate-limited without losing strict priority between the other queues.

Configuration inputs are expected to stay static while the block is out of reset. Each shaper's upper limit must be zero or above, and its lower limit zero or below.

Top module: `egress_prio_shaper`

## Requirements
- R1: Queue index n has higher priority than index n-1. On a grant, the arbiter selects the highest-indexed queue that is non-empty and not blocked by a shaper.
- R2: A grant is a one-cycle pulse on `tx_grant`, with `tx_queue` and `tx_len` (the head length of the chosen queue) held until the next grant. `tx_busy` rises with the grant and falls on the edge that samples `tx_done`. No grant occurs while `tx_busy` is high, so the earliest next grant is one cycle after that edge.
- R3: A queue with an active shaper whose credit is negative cannot be granted, even when it has the highest priority. A queue with no active shaper is eligible whenever it is non-empty.
- R4: An active shaper's credit rises by its idle rate on every cycle in which its queue is non-empty and not the queue in flight. The credit is frozen while its queue's frame is in flight.
- R5: On the cycle that samples `tx_done` for its queue's frame, an active shaper's credit falls by its send rate times `tx_bytes`.
- R6: While its queue is empty and not in flight, a positive credit is set to zero. A negative credit rises by the idle rate but never above zero.
- R7: Credit is clamped to the range from the shaper's lower limit to its upper limit.
- R8: A disabled shaper has no effect on any queue. When several enabled shapers name the same queue, only the lowest-numbered one gates it.
- R9: `tx_done` has no effect while `tx_busy` is low.
- R10: During reset and on the first cycle after it, `tx_grant` and `tx_busy` are low and every credit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q_ready | input | NQ | Per-queue non-empty flag |
| q_head_len | input | NQ*LW | Head frame length per queue, queue q at bits q*LW upward |
| cfg_en | input | NS | Per-shaper enable |
| cfg_queue | input | NS*QW | Queue index each shaper gates |
| cfg_idle | input | NS*SW | Credit gained per waiting cycle |
| cfg_send | input | NS*SW | Credit lost per byte sent |
| cfg_hi | input | NS*CW | Upper credit limit, signed |
| cfg_lo | input | NS*CW | Lower credit limit, signed |
| tx_done | input | 1 | Frame finished pulse from the transmit MAC |
| tx_bytes | input | LW | Bytes sent, valid with tx_done |
| tx_grant | output | 1 | One-cycle grant pulse |
| tx_queue | output | QW | Granted queue index |
| tx_len | output | LW | Head length of the granted queue |
| tx_busy | output | 1 | A granted frame is in flight |

## Verification
A queue state presented before edge N yields its grant at edge N when the arbiter is idle. A `tx_done` sampled at edge N frees the arbiter at that edge, so the next grant is due at edge N+1. A shaper's credit moves once per edge, so a shaped queue blocked at -C with idle rate I reopens exactly ceil(C/I) edges later. The bench keeps a cycle counter, and every expected grant carries the absolute cycle at which it is due. The monitor compares the queue index, the length and that cycle, so any early, late, missing or extra grant is reported.

// File: rtl/egress_prio_shaper.sv
module egress_prio_shaper #(
  parameter int NQ = 8,
  parameter int NS = 10,
  parameter int LW = 12,
  parameter int SW = 16,
  parameter int CW = 24,
  localparam int QW = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     q_ready,
  input  logic [NQ*LW-1:0]  q_head_len,
  input  logic [NS-1:0]     cfg_en,
  input  logic [NS*QW-1:0]  cfg_queue,
  input  logic [NS*SW-1:0]  cfg_idle,
  input  logic [NS*SW-1:0]  cfg_send,
  input  logic [NS*CW-1:0]  cfg_hi,
  input  logic [NS*CW-1:0]  cfg_lo,
  input  logic              tx_done,
  input  logic [LW-1:0]     tx_bytes,
  output logic              tx_grant,
  output logic [QW-1:0]     tx_queue,
  output logic [LW-1:0]     tx_len,
  output logic              tx_busy
);
  localparam int EW = CW + SW + LW + 1;

  logic [NS-1:0][CW-1:0] credit;
  logic [NS-1:0]         act;
  logic [NQ-1:0]         blocked, elig;
  logic [QW-1:0]         pick;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      act[s] = cfg_en[s];
      for (int j = 0; j < s; j++)
        if (cfg_en[j] && cfg_queue[j*QW +: QW] == cfg_queue[s*QW +: QW])
          act[s] = 1'b0;
    end
  end

  always_comb begin
    blocked = '0;
    for (int s = 0; s < NS; s++)
      if (act[s] && credit[s][CW-1])
        blocked[cfg_queue[s*QW +: QW]] = 1'b1;
  end

  assign elig = q_ready & ~blocked;

  always_comb begin
    pick = '0;
    for (int q = 0; q < NQ; q++)
      if (elig[q]) pick = QW'(q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_grant <= 1'b0;
      tx_busy  <= 1'b0;
      tx_queue <= '0;
      tx_len   <= '0;
    end else begin
      tx_grant <= 1'b0;
      if (tx_busy) begin
        if (tx_done) tx_busy <= 1'b0;
      end else if (|elig) begin
        tx_grant <= 1'b1;
        tx_busy  <= 1'b1;
        tx_queue <= pick;
        tx_len   <= q_head_len[int'(pick)*LW +: LW];
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_shp
    logic [QW-1:0]        qs;
    logic [SW+LW-1:0]     prod;
    logic signed [EW-1:0] cur, up, down, hi, lo, nxt;
    logic                 sending;

    assign qs      = cfg_queue[s*QW +: QW];
    assign sending = tx_busy && (tx_queue == qs);
    assign prod    = {{LW{1'b0}}, cfg_send[s*SW +: SW]} * {{SW{1'b0}}, tx_bytes};
    assign cur     = {{(EW-CW){credit[s][CW-1]}}, credit[s]};
    assign up      = cur + $signed({{(EW-SW){1'b0}}, cfg_idle[s*SW +: SW]});
    assign down    = cur - $signed({{(CW+1){1'b0}}, prod});
    assign hi      = {{(EW-CW){cfg_hi[s*CW+CW-1]}}, cfg_hi[s*CW +: CW]};
    assign lo      = {{(EW-CW){cfg_lo[s*CW+CW-1]}}, cfg_lo[s*CW +: CW]};

    always_comb begin
      nxt = cur;
      if (!act[s])             nxt = '0;
      else if (sending)        nxt = tx_done ? down : cur;
      else if (q_ready[qs])    nxt = up;
      else if (cur > 0)        nxt = '0;
      else if (cur < 0)        nxt = (up > 0) ? '0 : up;
      if (nxt > hi) nxt = hi;
      if (nxt < lo) nxt = lo;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) credit[s] <= '0;
      else        credit[s] <= nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/egress_prio_shaper_chk.sv
module egress_prio_shaper_chk #(
  parameter int NQ = 8,
  parameter int NS = 10,
  parameter int CW = 24,
  localparam int QW = $clog2(NQ)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NQ-1:0]         q_ready,
  input logic                  tx_grant,
  input logic [QW-1:0]         tx_queue,
  input logic                  tx_busy,
  input logic                  tx_done,
  input logic [NS-1:0][CW-1:0] credit,
  input logic [NS*CW-1:0]      cfg_hi,
  input logic [NS*CW-1:0]      cfg_lo
);
  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_grant && !tx_busy && credit == '0));

  // R2
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  // R2
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> (tx_busy && !tx_grant));

  // R2
  queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_grant) |-> $stable(tx_queue));

  // R1
  granted_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> ((($past(q_ready) >> tx_queue) & NQ'(1)) != '0));

  for (genvar s = 0; s < NS; s++) begin : g_lim
    // R7
    credit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(credit[s]) <= $signed(cfg_hi[s*CW +: CW])) &&
      ($signed(credit[s]) >= $signed(cfg_lo[s*CW +: CW])));
  end
endmodule

bind egress_prio_shaper egress_prio_shaper_chk #(.NQ(NQ), .NS(NS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_ready(q_ready), .tx_grant(tx_grant),
  .tx_queue(tx_queue), .tx_busy(tx_busy), .tx_done(tx_done),
  .credit(credit), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo));

// File: tb/test_egress_prio_shaper.sv
module test_egress_prio_shaper;
  localparam int NQ = 8, NS = 10, LW = 12, SW = 16, CW = 24, QW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NQ-1:0]    q_ready = '0;
  logic [NQ*LW-1:0] q_head_len;
  logic [NS-1:0]    cfg_en = '0;
  logic [NS*QW-1:0] cfg_queue = '0;
  logic [NS*SW-1:0] cfg_idle = '0, cfg_send = '0;
  logic [NS*CW-1:0] cfg_hi = '0, cfg_lo = '0;
  logic             tx_done = 1'b0;
  logic [LW-1:0]    tx_bytes = '0;
  logic             tx_grant, tx_busy;
  logic [QW-1:0]    tx_queue;
  logic [LW-1:0]    tx_len;

  egress_prio_shaper i_egress_prio_shaper (.*);

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  bit ended = 0;
  int    eq[$];
  int    ec[$];
  string et[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic want(int q, int c, string tag);
    eq.push_back(q); ec.push_back(c); et.push_back(tag);
  endtask

  task automatic go_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic done_pulse(int b);
    tx_done = 1'b1; tx_bytes = LW'(b);
    @(negedge clk);
    tx_done = 1'b0; tx_bytes = '0;
  endtask

  task automatic set_shp(int s, int q, int idle, int send, int hi, int lo);
    cfg_en[s] = 1'b1;
    cfg_queue[s*QW +: QW] = QW'(q);
    cfg_idle[s*SW +: SW]  = SW'(idle);
    cfg_send[s*SW +: SW]  = SW'(send);
    cfg_hi[s*CW +: CW]    = CW'(hi);
    cfg_lo[s*CW +: CW]    = CW'(lo);
  endtask

  // monitor: pops the scoreboard on every grant
  always @(negedge clk) begin
    if (rst_n && tx_grant) begin
      if (eq.size() == 0) begin
        check(1'b0, "R2 unexpected grant", int'(tx_queue), -1);
      end else begin
        int q, c;
        string t;
        q = eq.pop_front(); c = ec.pop_front(); t = et.pop_front();
        check(int'(tx_queue) == q, {t, " queue"}, int'(tx_queue), q);
        check(c == cyc, {t, " cycle"}, cyc, c);
        check(int'(tx_len) == q*16 + 3, "R2 length", int'(tx_len), q*16 + 3);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      while (eq.size() > 0) begin
        int q;
        q = eq.pop_front(); void'(ec.pop_front());
        check(1'b0, {et.pop_front(), " missing grant"}, -1, q);
      end
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t;
    for (int q = 0; q < NQ; q++) q_head_len[q*LW +: LW] = LW'(q*16 + 3);
    set_shp(0, 6, 1, 4, 100, -1000);
    set_shp(1, 4, 5, 1, 10000, -10000);
    set_shp(2, 5, 10, 1, 30, -1000);
    set_shp(3, 0, 2, 1, 1000, -20);
    set_shp(4, 1, 1, 0, 1000, -1000);
    set_shp(7, 1, 1, 100, 1000, -100000);
    set_shp(9, 7, 0, 1000, 0, -100000);
    cfg_en[9] = 1'b0;

    repeat (4) @(negedge clk);
    // R10
    check(!tx_grant && !tx_busy, "R10 reset outputs", {tx_grant, tx_busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_grant && !tx_busy, "R10 after reset", {tx_grant, tx_busy}, 0);
    go_to(cyc + 3);

    // R1 R3 R4 R5: shaped q6 blocked after sending, q1 wins, q6 reopens
    t = cyc;
    q_ready[6] = 1'b1; q_ready[1] = 1'b1;
    want(6, t + 1, "R1 highest eligible");
    want(1, t + 7, "R3 shaped queue blocked");
    want(6, t + 46, "R4 credit recovery while waiting");
    go_to(t + 4);
    check(tx_busy, "R2 busy in flight", tx_busy, 1);
    go_to(t + 5); done_pulse(10);
    go_to(t + 7); q_ready[1] = 1'b0; done_pulse(5);
    go_to(t + 50); q_ready[6] = 1'b0; done_pulse(0);
    check(!tx_busy, "R2 busy cleared", tx_busy, 0);
    go_to(cyc + 5);

    // R6: positive credit dropped on empty, negative recovers capped at zero
    t = cyc;
    q_ready[7] = 1'b1;
    want(7, t + 1, "R8 disabled shaper ignored");
    go_to(t + 1); q_ready[7] = 1'b0; q_ready[4] = 1'b1;
    go_to(t + 20); q_ready[4] = 1'b0; done_pulse(8);
    go_to(t + 22); q_ready[4] = 1'b1; q_ready[3] = 1'b1;
    want(4, t + 23, "R6 empty queue credit");
    want(3, t + 26, "R6 positive credit reset to zero");
    go_to(t + 24); q_ready[4] = 1'b0; done_pulse(30);
    go_to(t + 26); q_ready[3] = 1'b0; done_pulse(1);
    go_to(t + 40); q_ready[4] = 1'b1;
    want(4, t + 41, "R6 recovery while empty");
    want(3, t + 44, "R6 recovery capped at zero");
    want(4, t + 49, "R5 send slope per byte");
    go_to(t + 42); q_ready[3] = 1'b1; done_pulse(30);
    go_to(t + 44); q_ready[3] = 1'b0; done_pulse(1);
    go_to(t + 52); q_ready[4] = 1'b0; done_pulse(0);
    go_to(cyc + 5);

    // R7 upper limit
    t = cyc;
    q_ready[7] = 1'b1;
    want(7, t + 1, "R1 single queue");
    go_to(t + 1); q_ready[7] = 1'b0; q_ready[5] = 1'b1;
    go_to(t + 20); done_pulse(2);
    want(5, t + 22, "R2 next grant after done");
    want(2, t + 25, "R7 upper credit limit");
    want(5, t + 27, "R7 recovery from clamped value");
    go_to(t + 23); q_ready[2] = 1'b1; done_pulse(40);
    go_to(t + 25); q_ready[2] = 1'b0; done_pulse(1);
    go_to(t + 28); q_ready[5] = 1'b0; done_pulse(0);
    go_to(cyc + 5);

    // R7 lower limit, R9 idle done ignored
    t = cyc;
    q_ready[0] = 1'b1;
    want(0, t + 1, "R1 lowest queue");
    want(0, t + 14, "R7 lower credit limit");
    go_to(t + 2); done_pulse(100);
    go_to(t + 15); q_ready[0] = 1'b0; done_pulse(0);
    go_to(t + 20); done_pulse(200);
    check(!tx_busy && !tx_grant, "R9 idle done", {tx_busy, tx_grant}, 0);
    go_to(t + 22); q_ready[0] = 1'b1;
    want(0, t + 23, "R9 idle done ignored");
    go_to(t + 24); q_ready[0] = 1'b0; done_pulse(0);
    go_to(cyc + 5);

    // R2 no preemption, R8 duplicate mapping and disabled shaper
    t = cyc;
    q_ready[1] = 1'b1;
    want(1, t + 1, "R1 shaped queue with credit");
    go_to(t + 3); q_ready[7] = 1'b1;
    go_to(t + 6); done_pulse(50);
    want(7, t + 8, "R2 no preemption");
    want(1, t + 10, "R8 lower-numbered shaper rules");
    go_to(t + 8); q_ready[7] = 1'b0; done_pulse(3);
    go_to(t + 11); q_ready[1] = 1'b0; done_pulse(0);
    go_to(t + 12); q_ready[7] = 1'b1;
    want(7, t + 13, "R8 disabled shaper first");
    want(7, t + 16, "R8 disabled shaper repeat");
    go_to(t + 14); done_pulse(9);
    go_to(t + 16); q_ready[7] = 1'b0; done_pulse(0);
    go_to(cyc + 10);
    check(!tx_busy, "R2 final idle", tx_busy, 0);

    finish_run();
  end
endmodule